// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block is one periodic tick channel that sits on a simple word-addressed register bus. The input clock first goes through an 8-bit prescale stage and then through a fixed power-of-two divider, picked from four choices. The resulting tick clocks a 16-bit down-counter. Software writes the period minus one into a count buffer. It then copies that buffer into the live counter with a one-shot load bit, and finally sets the run and auto-reload bits together. From then on the counter decrements once per tick. At the tick that finds it at zero, it refills from the buffer and raises a one-cycle interrupt pulse.

A sticky pending flag records each refill until software clears it with a write of one. The live count can be read at any time through a read-only register. Because the buffer is only consulted at a refill or a one-shot load, software may rewrite it freely while the channel runs. Clearing the run bit freezes the counter and silences the interrupt.

Register map, by word address: 0 prescale configuration (prescale value in bits 15:8), 1 divider select (bits 1:0), 2 control (bit 0 run, bit 1 one-shot load, bit 2 auto-reload), 3 count buffer (bits 15:0), 4 live count (read-only), 5 pending flag (bit 0, write one to clear). Unmapped addresses read as zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the live count, the interrupt output, the pending flag and every writable register read as zero.
- R2: The prescale configuration register at address 0 stores all 32 written bits and reads them back unchanged; only bits 15:8 act as the prescale value.
- R3: The divider select in bits 1:0 of address 1 picks a divide of 2, 4, 8 or 16 for codes 0, 1, 2 and 3. One tick lasts P = (prescale + 1) * divide clock cycles, and the first decrement lands P cycles after the write that sets the run bit.
- R4: A control write with bit 1 set copies the count buffer into the live counter in that same clock edge. It does not set the run bit, and bit 1 always reads back as zero.
- R5: With run (bit 0) and auto-reload (bit 2) set and a buffer value N, the live count steps N, N-1, ..., 0 once per tick. The tick that finds the counter at zero refills it with N, so a full period is (N + 1) * P cycles.
- R6: The interrupt output is high for exactly one cycle, in the cycle that follows each refill edge, and at no other time.
- R7: The pending flag (address 5, bit 0) is set at every refill and is cleared by writing 1 to bit 0. If a refill and a clearing write meet in the same edge, the flag stays set.
- R8: While the run bit is clear (for example after a control write of zero), the live count holds its value, the prescale and divide stages restart from zero, and no interrupt or pending flag is raised.
- R9: A write to the count buffer does not alter the countdown in progress. The new value appears in the live count only at the next refill or one-shot load.
- R10: With run set and auto-reload clear, the counter decrements to zero and stays there, with no interrupt and no pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the source of the tick chain |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W (3) | Word address of the register accessed |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data for `addr`, combinational |
| irqPulse | output | 1 | One-cycle interrupt at each refill |

## Verification
Two collisions can share one edge: a refill that sets the pending flag and a software write that clears it, or a refill and a buffer write. The bench times its clearing write to land exactly on a known refill edge, using a short period (P = 2, N = 1). It then expects the flag to read as set, and expects it to read as clear after a second write that lands off the refill edge. For the buffer collision, the bench rewrites the buffer halfway through a countdown. It checks that the old sequence continues unchanged and that the new value appears exactly at the computed refill edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int CNT_W     = 16;
  parameter int PRE_W     = 8;
  parameter int PRE_LSB   = 8;
  parameter int DIV_SEL_W = 2;
  localparam int DIVCNT_W = 2 ** DIV_SEL_W;

  localparam int A_PRE  = 0;
  localparam int A_DIV  = 1;
  localparam int A_CTRL = 2;
  localparam int A_BUF  = 3;
  localparam int A_OBS  = 4;
  localparam int A_PEND = 5;

  localparam int CTL_RUN  = 0;
  localparam int CTL_LOAD = 1;
  localparam int CTL_AUTO = 2;

  typedef struct packed {
    logic                 run;
    logic                 autoReload;
    logic                 manualLoad;
    logic [PRE_W-1:0]     preVal;
    logic [DIV_SEL_W-1:0] divSel;
    logic [CNT_W-1:0]     bufVal;
  } tmrCtl_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              reloadEvt,
  input  logic [CNT_W-1:0]  liveCnt,
  output tmrCtl_t           ctl
);
  logic [DATA_W-1:0]    preCfg;
  logic [DIV_SEL_W-1:0] divCfg;
  logic                 runQ, autoQ, pendQ;
  logic [CNT_W-1:0]     bufQ;
  logic                 wrPre, wrDiv, wrCtrl, wrBuf, wrPend;

  assign wrPre  = wrEn && (int'(addr) == A_PRE);
  assign wrDiv  = wrEn && (int'(addr) == A_DIV);
  assign wrCtrl = wrEn && (int'(addr) == A_CTRL);
  assign wrBuf  = wrEn && (int'(addr) == A_BUF);
  assign wrPend = wrEn && (int'(addr) == A_PEND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCfg <= '0;
      divCfg <= '0;
      runQ   <= 1'b0;
      autoQ  <= 1'b0;
      bufQ   <= '0;
      pendQ  <= 1'b0;
    end else begin
      if (wrPre) preCfg <= wrData;
      if (wrDiv) divCfg <= wrData[DIV_SEL_W-1:0];
      if (wrCtrl) begin
        runQ  <= wrData[CTL_RUN];
        autoQ <= wrData[CTL_AUTO];
      end
      if (wrBuf) bufQ <= wrData[CNT_W-1:0];
      // a refill in the same edge as a clearing write keeps the flag set
      pendQ <= reloadEvt | (pendQ & ~(wrPend & wrData[0]));
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.run        = runQ;
    ctl.autoReload = autoQ;
    ctl.manualLoad = wrCtrl && wrData[CTL_LOAD];
    ctl.preVal     = preCfg[PRE_LSB +: PRE_W];
    ctl.divSel     = divCfg;
    ctl.bufVal     = bufQ;
  end

  always_comb begin
    rdData = '0;
    case (int'(addr))
      A_PRE:  rdData = preCfg;
      A_DIV:  rdData[DIV_SEL_W-1:0] = divCfg;
      A_CTRL: begin
        rdData[CTL_RUN]  = runQ;
        rdData[CTL_AUTO] = autoQ;
      end
      A_BUF:  rdData[CNT_W-1:0] = bufQ;
      A_OBS:  rdData[CNT_W-1:0] = liveCnt;
      A_PEND: rdData[0] = pendQ;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrCtl_t          ctl,
  output logic [CNT_W-1:0] cnt,
  output logic             reloadEvt,
  output logic             irqPulse
);
  logic [PRE_W-1:0]    preCnt;
  logic [DIVCNT_W-1:0] divCnt, divLimit;
  logic                preWrap, divWrap, tick;

  assign divLimit  = DIVCNT_W'((32'd2 << ctl.divSel) - 32'd1);
  // >= keeps the stage sane if the limit is lowered mid-count
  assign preWrap   = preCnt >= ctl.preVal;
  assign divWrap   = divCnt >= divLimit;
  assign tick      = ctl.run && preWrap && divWrap;
  assign reloadEvt = tick && (cnt == '0) && ctl.autoReload && !ctl.manualLoad;

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.run) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= reloadEvt;
      if (ctl.manualLoad)     cnt <= ctl.bufVal;
      else if (tick) begin
        if (cnt != '0)        cnt <= cnt - 1'b1;
        else if (ctl.autoReload) cnt <= ctl.bufVal;
      end
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPulse
);
  tmrCtl_t          ctlBus;
  logic [CNT_W-1:0] liveCnt;
  logic             reloadEvt;

  tmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .reloadEvt(reloadEvt), .liveCnt(liveCnt), .ctl(ctlBus)
  );

  tmr_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .cnt(liveCnt),
    .reloadEvt(reloadEvt), .irqPulse(irqPulse)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             irqPulse,
  input tmrCtl_t          ctlBus,
  input logic [CNT_W-1:0] liveCnt
);
  // R6: the interrupt never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R5: the interrupt cycle shows the buffer value just refilled
  a_r5_refill_value: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> liveCnt == $past(ctlBus.bufVal));

  // R4: a one-shot load puts the buffer into the counter
  a_r4_manual_copy: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.manualLoad |=> liveCnt == $past(ctlBus.bufVal));

  // R8: stopped channel holds its count
  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlBus.run && !ctlBus.manualLoad) |=> $stable(liveCnt));

  // R8: stopped channel raises no interrupt
  a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !ctlBus.run |=> !irqPulse);

  // R10: without auto-reload, zero is final
  a_r10_stay_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlBus.autoReload && !ctlBus.manualLoad && liveCnt == '0) |=> liveCnt == '0);
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .irqPulse(irqPulse), .ctlBus(ctlBus), .liveCnt(liveCnt)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqPulse;
  int          nRun = 0;
  int          nFail = 0;

  always #10 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input int a, input logic [31:0] d);
    wrEn = 1'b1; addr = 3'(a); wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 3'(a);
    #1;
    d = rdData;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk(v == 0, $sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk(irqPulse == 1'b0, "R1 irq after reset", irqPulse, 0);

    // R2 full readback of prescale register
    wr(0, 32'hA5A5_03C3);
    rd(0, v);
    chk(v == 32'hA5A5_03C3, "R2 prescale register readback", v, 32'hA5A5_03C3);

    // R3 R5 R6 sweep: prescale x divider x period
    for (int pre = 0; pre < 3; pre++) begin
      for (int ds = 0; ds < 4; ds++) begin
        for (int ni = 0; ni < 3; ni++) begin
          int n, p, lim, mism, irqBad;
          n = (ni == 2) ? 3 : ni;
          p = (pre + 1) * (2 << ds);
          lim = 2 * (n + 1) * p + 3;
          wr(2, 0);
          wr(5, 1);
          wr(0, 32'hFF00_00FF | (pre << 8));
          wr(1, ds);
          wr(3, n);
          wr(2, 32'h2);
          rd(4, v);
          chk(v == n, "R4 one-shot load copies buffer", v, n);
          rd(2, v);
          chk(v == 0, "R4 load leaves run clear, bit reads zero", v, 0);
          wr(2, 32'h5);
          addr = 3'd4;
          mism = 0; irqBad = 0;
          for (int x = 0; x <= lim; x++) begin
            int expCnt;
            bit expIrq;
            expCnt = n - ((x / p) % (n + 1));
            expIrq = (x > 0) && (x % ((n + 1) * p) == 0);
            #1;
            if (rdData != expCnt && mism == 0) begin
              mism = 1;
              chk(0, $sformatf("R3/R5 count pre=%0d ds=%0d n=%0d x=%0d", pre, ds, n, x), rdData, expCnt);
            end
            if (irqPulse != expIrq && irqBad == 0) begin
              irqBad = 1;
              chk(0, $sformatf("R6 irq pre=%0d ds=%0d n=%0d x=%0d", pre, ds, n, x), irqPulse, expIrq);
            end
            @(negedge clk);
          end
          chk(mism == 0, "R5 count sequence matched", mism, 0);
          chk(irqBad == 0, "R6 irq timing matched", irqBad, 0);
        end
      end
    end

    // R8 stop holds count, no irq, pending stays clear
    begin
      logic [31:0] held;
      int seenIrq;
      wr(5, 1);
      wr(2, 0);
      rd(4, held);
      seenIrq = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (irqPulse) seenIrq++;
      end
      rd(4, v);
      chk(v == held, "R8 count holds while stopped", v, held);
      chk(seenIrq == 0, "R8 no irq while stopped", seenIrq, 0);
      rd(5, v);
      chk(v == 0, "R8 pending stays clear while stopped", v, 0);
    end

    // R9 buffer rewrite mid-countdown (P=2, N=3)
    wr(0, 0); wr(1, 0); wr(3, 3); wr(2, 32'h2); wr(2, 32'h5);
    repeat (3) @(negedge clk);
    wr(3, 5);
    rd(4, v);
    chk(v == 1, "R9 old countdown continues after buffer write", v, 1);
    repeat (4) @(negedge clk);
    #1;
    chk(irqPulse == 1'b1, "R6 irq at refill after buffer write", irqPulse, 1);
    rd(4, v);
    chk(v == 5, "R9 new buffer value at next refill", v, 5);

    // R7 pending flag: collision with refill, then plain clear (P=2, N=1)
    wr(2, 0); wr(5, 1); wr(3, 1); wr(2, 32'h2);
    rd(5, v);
    chk(v == 0, "R7 pending clear before start", v, 0);
    wr(2, 32'h5);
    repeat (7) @(negedge clk);
    wr(5, 1);
    rd(5, v);
    chk(v == 1, "R7 refill wins over same-edge clear", v, 1);
    wr(5, 1);
    rd(5, v);
    chk(v == 0, "R7 write one clears pending", v, 0);

    // R10 no auto-reload: stop at zero, no irq
    begin
      int seenIrq;
      wr(2, 0); wr(5, 1); wr(3, 2); wr(2, 32'h2); wr(2, 32'h1);
      seenIrq = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (irqPulse) seenIrq++;
      end
      rd(4, v);
      chk(v == 0, "R10 count rests at zero", v, 0);
      chk(seenIrq == 0, "R10 no irq without auto-reload", seenIrq, 0);
      rd(5, v);
      chk(v == 0, "R10 no pending without auto-reload", v, 0);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule